// File: doc/BRIEF.md
# DRAM Reclock Command Sequencer

This block walks a DRAM device through the full command sequence that lets the memory clock frequency change without losing contents. A single start pulse launches a run for one of three memory families. The caller also supplies the target values for mode registers 0, 1 and 2. The sequencer first reads back the mode registers the device currently holds. It then optionally turns the DLL off and parks the device in self-refresh. Next it asks outside logic to switch the clock, brings the device back out of self-refresh, and rewrites only the mode registers that change. After that it asks outside logic to load the new timing registers and, when the DLL stays enabled, runs a DLL reset followed by the lock wait.

Every external action goes through a request/acknowledge pair: mode-register reads, DRAM commands, the clock switch and the timing-register load. The device, the PLL and the timing contents all sit outside the block. Every delay is given in nanoseconds and converted at elaboration into clock cycles using a clock-period parameter.

Top module: `dram_reclock_seq`

## Requirements
- R1: After reset, and at any time while idle, `busy_o`, `done_o` and `err_o` are low and none of `cmd_valid_o`, `mrrd_req_o`, `clk_req_o`, `tim_req_o` is asserted.
- R2: The memory type select is encoded 0 = DDR2, 1 = DDR3, 2 = GDDR3. A start with type 3 raises `err_o` for exactly one cycle, the cycle after the start. It issues no request of any kind and leaves `busy_o` low.
- R3: A run first reads mode register 1 and then mode register 0, with the register number on `mrrd_idx_o` and the value taken on `mrrd_ack_i`. It reads mode register 2 third, and only for DDR3. For the other types the current value of register 2 is taken to equal its target.
- R4: The DLL-disable flag of mode register 1 is bit 0 for DDR2 and DDR3 and bit 6 for GDDR3. If the current register 1 has the flag clear and the target has it set, the sequencer issues a precharge, then a mode-register-set of register 1 with the current value plus the flag, then the mode-register-set delay, all before self-refresh entry.
- R5: Self-refresh entry is: precharge, refresh, refresh, auto-refresh off, self-refresh on, then the entry delay. The clock-switch handshake follows. The exit is: exit delay, precharge, self-refresh off, auto-refresh on, then the exit-to-command delay.
- R6: Mode registers 2, 1 and 0 are then rewritten in that order. Each is written only when its current value differs from its target, and each write is followed by the mode-register-set delay.
- R7: After the timing-load handshake, and only if the target leaves the DLL enabled, the sequencer runs the DLL reset. It writes register 0 as target with bit 8 set, waits the set delay, writes register 0 as target with bit 8 clear, waits the set delay, and then waits the DLL lock time (2000 ns DDR2, 12000 ns DDR3, 40000 ns GDDR3). GDDR3 then issues one more precharge.
- R8: Each delay lasts ceil(ns*1000 / CLK_PERIOD_PS) cycles. A delay of zero cycles adds no cycles. The mode-register-set delay is 1000 ns by default.
- R9: `cmd_o` is one-hot: bit 0 precharge, bit 1 refresh, bit 2 auto-refresh off, bit 3 auto-refresh on, bit 4 self-refresh on, bit 5 self-refresh off, bit 6 mode-register set (register number on `cmd_mr_idx_o`, value on `cmd_mr_data_o`). A command stays valid and unchanged until `cmd_ready_i`. At most one request output is high at a time.
- R10: `busy_o` rises the cycle after an accepted start and falls when the run ends. `done_o` pulses for one cycle as `busy_o` falls. A start while busy is ignored: no error, and the running sequence continues with its original targets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| mem_kind_i | input | 2 | Memory type select |
| tgt_mr0_i | input | MR_W | Target mode register 0 |
| tgt_mr1_i | input | MR_W | Target mode register 1 |
| tgt_mr2_i | input | MR_W | Target mode register 2 |
| mrrd_req_o | output | 1 | Mode-register read request |
| mrrd_idx_o | output | 2 | Register number to read |
| mrrd_ack_i | input | 1 | Read acknowledge, data valid |
| mrrd_data_i | input | MR_W | Read data |
| cmd_valid_o | output | 1 | Command valid |
| cmd_ready_i | input | 1 | Command accepted |
| cmd_o | output | 7 | One-hot command |
| cmd_mr_idx_o | output | 2 | Register number for mode-register set |
| cmd_mr_data_o | output | MR_W | Value for mode-register set |
| clk_req_o | output | 1 | Request to switch the memory clock |
| clk_ack_i | input | 1 | Clock switch complete |
| tim_req_o | output | 1 | Request to load new timing registers |
| tim_ack_i | input | 1 | Timing load complete |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle unsupported-type pulse |

## Verification
The hardest situation to reach from the ports is a start that lands in the middle of a run while a handshake is stalled. It must leave the run untouched. The bench pokes a type-3 start while the clock-switch request is waiting for its acknowledge. It then checks that no error pulse appears and that the remaining command stream still matches the original targets. The stimulus also stalls every handshake on a rotating pattern, and it picks device contents so that each conditional branch is both taken and skipped. These include the GDDR3 case where bit 0 is set but the DLL is still on.

// File: rtl/dram_reclock_pkg.sv
package dram_reclock_pkg;

    typedef enum logic [1:0] {
        MEM_DDR2  = 2'd0,
        MEM_DDR3  = 2'd1,
        MEM_GDDR3 = 2'd2,
        MEM_BAD   = 2'd3
    } mem_kind_e;

    localparam int CMD_W    = 7;
    localparam int C_PRE    = 0;
    localparam int C_REF    = 1;
    localparam int C_AR_OFF = 2;
    localparam int C_AR_ON  = 3;
    localparam int C_SR_ON  = 4;
    localparam int C_SR_OFF = 5;
    localparam int C_MRS    = 6;

    typedef enum logic [2:0] {
        OP_READ,
        OP_CMD,
        OP_WAIT,
        OP_CLK,
        OP_TIM,
        OP_END
    } op_kind_e;

    function automatic int ns_to_cyc(int ns, int period_ps);
        return (ns * 1000 + period_ps - 1) / period_ps;
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dram_reclock_timer.sv
module dram_reclock_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             last_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        last_o = run_i && (cnt_q == limit_i - CNT_W'(1));
        if (!run_i || last_o) cnt_d = '0;
        else                  cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/dram_reclock_step_dec.sv
module dram_reclock_step_dec
    import dram_reclock_pkg::*;
#(
    parameter int MR_W     = 16,
    parameter int CNT_W    = 8,
    parameter int STEP_W   = 5,
    parameter int MRD_C    = 1,
    parameter int SRE_C    = 0,
    parameter int SRX_C    = 0,
    parameter int XS_C     = 0,
    parameter int DLL2_C   = 1,
    parameter int DLL3_C   = 1,
    parameter int DLLG_C   = 1
) (
    input  logic [STEP_W-1:0] step_i,
    input  mem_kind_e         kind_i,
    input  logic [MR_W-1:0]   cur0_i,
    input  logic [MR_W-1:0]   cur1_i,
    input  logic [MR_W-1:0]   cur2_i,
    input  logic [MR_W-1:0]   tgt0_i,
    input  logic [MR_W-1:0]   tgt1_i,
    input  logic [MR_W-1:0]   tgt2_i,
    output logic              en_o,
    output op_kind_e          op_o,
    output logic [CMD_W-1:0]  cmd_o,
    output logic [1:0]        idx_o,
    output logic [MR_W-1:0]   data_o,
    output logic [CNT_W-1:0]  cyc_o
);
    localparam logic [MR_W-1:0] RST_BIT = MR_W'(1) << 8;

    logic [MR_W-1:0]  dll_mask;
    logic             dll_entry, dll_keep;
    logic [CNT_W-1:0] lock_cyc;

    always_comb begin
        dll_mask  = (kind_i == MEM_GDDR3) ? (MR_W'(1) << 6) : MR_W'(1);
        dll_entry = ((cur1_i & dll_mask) == '0) && ((tgt1_i & dll_mask) != '0);
        dll_keep  = ((tgt1_i & dll_mask) == '0);
        case (kind_i)
            MEM_DDR2: lock_cyc = CNT_W'(DLL2_C);
            MEM_DDR3: lock_cyc = CNT_W'(DLL3_C);
            default:  lock_cyc = CNT_W'(DLLG_C);
        endcase
    end

    always_comb begin
        en_o   = 1'b1;
        op_o   = OP_CMD;
        cmd_o  = '0;
        idx_o  = 2'd0;
        data_o = '0;
        cyc_o  = CNT_W'(MRD_C);
        case (step_i)
            // current-value read-back
            5'd0:  begin op_o = OP_READ; idx_o = 2'd1; end
            5'd1:  begin op_o = OP_READ; idx_o = 2'd0; end
            5'd2:  begin op_o = OP_READ; idx_o = 2'd2; en_o = (kind_i == MEM_DDR3); end
            // DLL-off entry
            5'd3:  begin cmd_o[C_PRE] = 1'b1; en_o = dll_entry; end
            5'd4:  begin cmd_o[C_MRS] = 1'b1; idx_o = 2'd1; data_o = cur1_i | dll_mask; en_o = dll_entry; end
            5'd5:  begin op_o = OP_WAIT; en_o = dll_entry && (MRD_C != 0); end
            // self-refresh entry
            5'd6:  cmd_o[C_PRE]    = 1'b1;
            5'd7:  cmd_o[C_REF]    = 1'b1;
            5'd8:  cmd_o[C_REF]    = 1'b1;
            5'd9:  cmd_o[C_AR_OFF] = 1'b1;
            5'd10: cmd_o[C_SR_ON]  = 1'b1;
            5'd11: begin op_o = OP_WAIT; cyc_o = CNT_W'(SRE_C); en_o = (SRE_C != 0); end
            5'd12: op_o = OP_CLK;
            // self-refresh exit
            5'd13: begin op_o = OP_WAIT; cyc_o = CNT_W'(SRX_C); en_o = (SRX_C != 0); end
            5'd14: cmd_o[C_PRE]    = 1'b1;
            5'd15: cmd_o[C_SR_OFF] = 1'b1;
            5'd16: cmd_o[C_AR_ON]  = 1'b1;
            5'd17: begin op_o = OP_WAIT; cyc_o = CNT_W'(XS_C); en_o = (XS_C != 0); end
            // conditional rewrites 2, 1, 0
            5'd18: begin cmd_o[C_MRS] = 1'b1; idx_o = 2'd2; data_o = tgt2_i; en_o = (cur2_i != tgt2_i); end
            5'd19: begin op_o = OP_WAIT; en_o = (cur2_i != tgt2_i) && (MRD_C != 0); end
            5'd20: begin cmd_o[C_MRS] = 1'b1; idx_o = 2'd1; data_o = tgt1_i; en_o = (cur1_i != tgt1_i); end
            5'd21: begin op_o = OP_WAIT; en_o = (cur1_i != tgt1_i) && (MRD_C != 0); end
            5'd22: begin cmd_o[C_MRS] = 1'b1; idx_o = 2'd0; data_o = tgt0_i; en_o = (cur0_i != tgt0_i); end
            5'd23: begin op_o = OP_WAIT; en_o = (cur0_i != tgt0_i) && (MRD_C != 0); end
            5'd24: op_o = OP_TIM;
            // DLL reset
            5'd25: begin cmd_o[C_MRS] = 1'b1; data_o = tgt0_i | RST_BIT; en_o = dll_keep; end
            5'd26: begin op_o = OP_WAIT; en_o = dll_keep && (MRD_C != 0); end
            5'd27: begin cmd_o[C_MRS] = 1'b1; data_o = tgt0_i & ~RST_BIT; en_o = dll_keep; end
            5'd28: begin op_o = OP_WAIT; en_o = dll_keep && (MRD_C != 0); end
            5'd29: begin op_o = OP_WAIT; cyc_o = lock_cyc; en_o = dll_keep && (lock_cyc != '0); end
            5'd30: begin cmd_o[C_PRE] = 1'b1; en_o = dll_keep && (kind_i == MEM_GDDR3); end
            default: op_o = OP_END;
        endcase
    end
endmodule

// File: rtl/dram_reclock_seq.sv
module dram_reclock_seq
    import dram_reclock_pkg::*;
#(
    parameter int MR_W            = 16,
    parameter int CLK_PERIOD_PS   = 8000,
    parameter int T_MRD_NS        = 1000,
    parameter int T_SRE_NS        = 0,
    parameter int T_SRX_NS        = 0,
    parameter int T_XS_NS         = 0,
    parameter int T_DLL_DDR2_NS   = 2000,
    parameter int T_DLL_DDR3_NS   = 12000,
    parameter int T_DLL_GDDR3_NS  = 40000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [1:0]      mem_kind_i,
    input  logic [MR_W-1:0] tgt_mr0_i,
    input  logic [MR_W-1:0] tgt_mr1_i,
    input  logic [MR_W-1:0] tgt_mr2_i,
    output logic            mrrd_req_o,
    output logic [1:0]      mrrd_idx_o,
    input  logic            mrrd_ack_i,
    input  logic [MR_W-1:0] mrrd_data_i,
    output logic            cmd_valid_o,
    input  logic            cmd_ready_i,
    output logic [6:0]      cmd_o,
    output logic [1:0]      cmd_mr_idx_o,
    output logic [MR_W-1:0] cmd_mr_data_o,
    output logic            clk_req_o,
    input  logic            clk_ack_i,
    output logic            tim_req_o,
    input  logic            tim_ack_i,
    output logic            busy_o,
    output logic            done_o,
    output logic            err_o
);
    localparam int MRD_C  = ns_to_cyc(T_MRD_NS, CLK_PERIOD_PS);
    localparam int SRE_C  = ns_to_cyc(T_SRE_NS, CLK_PERIOD_PS);
    localparam int SRX_C  = ns_to_cyc(T_SRX_NS, CLK_PERIOD_PS);
    localparam int XS_C   = ns_to_cyc(T_XS_NS, CLK_PERIOD_PS);
    localparam int DLL2_C = ns_to_cyc(T_DLL_DDR2_NS, CLK_PERIOD_PS);
    localparam int DLL3_C = ns_to_cyc(T_DLL_DDR3_NS, CLK_PERIOD_PS);
    localparam int DLLG_C = ns_to_cyc(T_DLL_GDDR3_NS, CLK_PERIOD_PS);
    localparam int MAX_C  = imax(imax(imax(MRD_C, SRE_C), imax(SRX_C, XS_C)),
                                 imax(imax(DLL2_C, DLL3_C), DLLG_C));
    localparam int CNT_W  = (MAX_C < 2) ? 1 : $clog2(MAX_C + 1);
    localparam int STEP_W = 5;

    typedef struct packed {
        logic              run;
        logic [STEP_W-1:0] step;
        mem_kind_e         kind;
        logic [MR_W-1:0]   cur0;
        logic [MR_W-1:0]   cur1;
        logic [MR_W-1:0]   cur2;
        logic [MR_W-1:0]   tgt0;
        logic [MR_W-1:0]   tgt1;
        logic [MR_W-1:0]   tgt2;
        logic              done;
        logic              err;
    } seq_t;

    seq_t s_d, s_q;

    logic             op_en;
    op_kind_e         op_kind;
    logic [CMD_W-1:0] op_cmd;
    logic [1:0]       op_idx;
    logic [MR_W-1:0]  op_data;
    logic [CNT_W-1:0] op_cyc;
    logic             wait_run, wait_last;
    logic             live, advance;

    dram_reclock_step_dec #(
        .MR_W(MR_W), .CNT_W(CNT_W), .STEP_W(STEP_W),
        .MRD_C(MRD_C), .SRE_C(SRE_C), .SRX_C(SRX_C), .XS_C(XS_C),
        .DLL2_C(DLL2_C), .DLL3_C(DLL3_C), .DLLG_C(DLLG_C)
    ) u_dec (
        .step_i (s_q.step),
        .kind_i (s_q.kind),
        .cur0_i (s_q.cur0),
        .cur1_i (s_q.cur1),
        .cur2_i (s_q.cur2),
        .tgt0_i (s_q.tgt0),
        .tgt1_i (s_q.tgt1),
        .tgt2_i (s_q.tgt2),
        .en_o   (op_en),
        .op_o   (op_kind),
        .cmd_o  (op_cmd),
        .idx_o  (op_idx),
        .data_o (op_data),
        .cyc_o  (op_cyc)
    );

    assign wait_run = live && (op_kind == OP_WAIT);

    dram_reclock_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (wait_run),
        .limit_i (op_cyc),
        .last_o  (wait_last)
    );

    always_comb begin
        live          = s_q.run && op_en;
        mrrd_req_o    = live && (op_kind == OP_READ);
        mrrd_idx_o    = op_idx;
        cmd_valid_o   = live && (op_kind == OP_CMD);
        cmd_o         = cmd_valid_o ? op_cmd : '0;
        cmd_mr_idx_o  = op_idx;
        cmd_mr_data_o = op_data;
        clk_req_o     = live && (op_kind == OP_CLK);
        tim_req_o     = live && (op_kind == OP_TIM);
        busy_o        = s_q.run;
        done_o        = s_q.done;
        err_o         = s_q.err;

        advance = !op_en
               || (mrrd_req_o  && mrrd_ack_i)
               || (cmd_valid_o && cmd_ready_i)
               || (clk_req_o   && clk_ack_i)
               || (tim_req_o   && tim_ack_i)
               || wait_last;

        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.err  = 1'b0;
        if (!s_q.run) begin
            if (start_i) begin
                if (mem_kind_e'(mem_kind_i) == MEM_BAD) begin
                    s_d.err = 1'b1;
                end else begin
                    s_d.run  = 1'b1;
                    s_d.step = '0;
                    s_d.kind = mem_kind_e'(mem_kind_i);
                    s_d.tgt0 = tgt_mr0_i;
                    s_d.tgt1 = tgt_mr1_i;
                    s_d.tgt2 = tgt_mr2_i;
                    s_d.cur0 = '0;
                    s_d.cur1 = '0;
                    s_d.cur2 = tgt_mr2_i;
                end
            end
        end else if (op_en && (op_kind == OP_END)) begin
            s_d.run  = 1'b0;
            s_d.done = 1'b1;
        end else if (advance) begin
            s_d.step = s_q.step + STEP_W'(1);
            if (mrrd_req_o) begin
                case (op_idx)
                    2'd0:    s_d.cur0 = mrrd_data_i;
                    2'd1:    s_d.cur1 = mrrd_data_i;
                    default: s_d.cur2 = mrrd_data_i;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.kind <= MEM_DDR2;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/dram_reclock_seq_chk.sv
module dram_reclock_seq_chk #(
    parameter int MR_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic            mrrd_req_o,
    input logic            mrrd_ack_i,
    input logic            cmd_valid_o,
    input logic            cmd_ready_i,
    input logic [6:0]      cmd_o,
    input logic [1:0]      cmd_mr_idx_o,
    input logic [MR_W-1:0] cmd_mr_data_o,
    input logic            clk_req_o,
    input logic            clk_ack_i,
    input logic            tim_req_o,
    input logic            tim_ack_i,
    input logic            busy_o,
    input logic            done_o,
    input logic            err_o
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !(cmd_valid_o || mrrd_req_o || clk_req_o || tim_req_o));

    // R2
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !busy_o && !$past(busy_o));

    // R9
    cmd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> $countones(cmd_o) == 1);

    // R9
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_o)
            && $stable(cmd_mr_idx_o) && $stable(cmd_mr_data_o));

    // R9
    single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_valid_o, mrrd_req_o, clk_req_o, tim_req_o}));

    // R3
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mrrd_req_o && !mrrd_ack_i |=> mrrd_req_o);

    // R5
    clk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_req_o && !clk_ack_i |=> clk_req_o);

    // R7
    tim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tim_req_o && !tim_ack_i |=> tim_req_o);

    // R10
    done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o && $past(busy_o));

    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && start_i |=> !err_o);
endmodule

bind dram_reclock_seq dram_reclock_seq_chk #(.MR_W(MR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .mrrd_req_o    (mrrd_req_o),
    .mrrd_ack_i    (mrrd_ack_i),
    .cmd_valid_o   (cmd_valid_o),
    .cmd_ready_i   (cmd_ready_i),
    .cmd_o         (cmd_o),
    .cmd_mr_idx_o  (cmd_mr_idx_o),
    .cmd_mr_data_o (cmd_mr_data_o),
    .clk_req_o     (clk_req_o),
    .clk_ack_i     (clk_ack_i),
    .tim_req_o     (tim_req_o),
    .tim_ack_i     (tim_ack_i),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .err_o         (err_o)
);

// File: tb/dram_reclock_seq_bench.sv
module dram_reclock_seq_bench;
    localparam int MR_W   = 16;
    localparam int PER_PS = 8000;
    localparam int SRE_NS = 100;
    localparam int SRX_NS = 0;
    localparam int XS_NS  = 170;
    localparam int SLACK  = 20;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic [1:0]      mem_kind_i = 2'd0;
    logic [MR_W-1:0] tgt_mr0_i = '0, tgt_mr1_i = '0, tgt_mr2_i = '0;
    logic            mrrd_req_o, mrrd_ack_i = 1'b0;
    logic [1:0]      mrrd_idx_o;
    logic [MR_W-1:0] mrrd_data_i = '0;
    logic            cmd_valid_o, cmd_ready_i = 1'b0;
    logic [6:0]      cmd_o;
    logic [1:0]      cmd_mr_idx_o;
    logic [MR_W-1:0] cmd_mr_data_o;
    logic            clk_req_o, clk_ack_i = 1'b0;
    logic            tim_req_o, tim_ack_i = 1'b0;
    logic            busy_o, done_o, err_o;

    always #4 clk = ~clk;

    dram_reclock_seq #(
        .MR_W(MR_W), .CLK_PERIOD_PS(PER_PS),
        .T_SRE_NS(SRE_NS), .T_SRX_NS(SRX_NS), .T_XS_NS(XS_NS)
    ) u_dram_reclock_seq (.*);

    int total = 0, bad = 0, cyc = 0, gap = 0, pend = 0, done_min = 0;
    int done_cnt = 0, err_cnt = 0;
    bit busy_prev = 1'b0, finished = 1'b0;
    logic [MR_W-1:0] dev [3];
    int              eq_kind[$], eq_idx[$], eq_min[$];
    logic [MR_W-1:0] eq_data[$];
    string           eq_req[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int ns2c(int ns);
        int c;
        c = (ns * 1000) / PER_PS;
        if (c * PER_PS < ns * 1000) c++;
        return c;
    endfunction

    // kinds: 0..6 command bit, 7 clock switch, 8 timing load, 9 read
    task automatic push(input int k, input int idx, input logic [MR_W-1:0] d, input string req);
        eq_kind.push_back(k); eq_idx.push_back(idx); eq_data.push_back(d);
        eq_min.push_back(pend + 1); eq_req.push_back(req);
        pend = 0;
    endtask

    task automatic build(input int kind, input logic [MR_W-1:0] t0, t1, t2);
        logic [MR_W-1:0] mask, c0, c1, c2;
        int mrd, lock;
        mask = (kind == 2) ? 16'h0040 : 16'h0001;
        lock = (kind == 0) ? 2000 : (kind == 1) ? 12000 : 40000;
        mrd  = ns2c(1000);
        c0 = dev[0]; c1 = dev[1]; c2 = (kind == 1) ? dev[2] : t2;
        pend = -1;
        push(9, 1, 0, "R3"); push(9, 0, 0, "R3");
        if (kind == 1) push(9, 2, 0, "R3");
        if ((c1 & mask) == 0 && (t1 & mask) != 0) begin
            push(0, -1, 0, "R4"); push(6, 1, c1 | mask, "R4"); pend += mrd;
        end
        push(0, -1, 0, "R5"); push(1, -1, 0, "R5"); push(1, -1, 0, "R5");
        push(2, -1, 0, "R5"); push(4, -1, 0, "R5"); pend += ns2c(SRE_NS);
        push(7, -1, 0, "R5"); pend += ns2c(SRX_NS);
        push(0, -1, 0, "R5"); push(5, -1, 0, "R5"); push(3, -1, 0, "R5"); pend += ns2c(XS_NS);
        if (c2 != t2) begin push(6, 2, t2, "R6"); pend += mrd; end
        if (c1 != t1) begin push(6, 1, t1, "R6"); pend += mrd; end
        if (c0 != t0) begin push(6, 0, t0, "R6"); pend += mrd; end
        push(8, -1, 0, "R7");
        if ((t1 & mask) == 0) begin
            push(6, 0, t0 | 16'h0100, "R7"); pend += mrd;
            push(6, 0, t0 & ~16'h0100, "R7"); pend += mrd + ns2c(lock);
            if (kind == 2) push(0, -1, 0, "R7");
        end
        done_min = pend + 2;
    endtask

    task automatic take(input int k, input int idx, input logic [MR_W-1:0] d);
        int ek, ei, em; logic [MR_W-1:0] ed; string er;
        if (eq_kind.size() == 0) begin
            chk(0, "R9", "unexpected request", k, -1);
            return;
        end
        ek = eq_kind.pop_front(); ei = eq_idx.pop_front(); ed = eq_data.pop_front();
        em = eq_min.pop_front();  er = eq_req.pop_front();
        chk(k == ek, er, "event kind", k, ek);
        if (ei >= 0) chk(idx == ei, er, "register number", idx, ei);
        if (ek == 6) chk(d == ed, er, "mode register value", d, ed);
        if (em > 0) begin
            chk(gap >= em, "R8", "cycles before event", gap, em);
            chk(gap <= em + SLACK, "R8", "event too late", gap, em + SLACK);
        end
    endtask

    always @(negedge clk) begin
        bit rdy, ar, ac, at;
        int k;
        if (rst_n) begin
            cyc++; gap++;
            if (start_i && !busy_prev) gap = 0;
            rdy = cmd_valid_o && (cyc % 3 != 0);
            ar  = mrrd_req_o && (cyc % 2 == 0);
            ac  = clk_req_o && (cyc % 4 == 0);
            at  = tim_req_o && (cyc % 4 == 1);
            if (!busy_o && (cmd_valid_o || mrrd_req_o || clk_req_o || tim_req_o))
                chk(0, "R1", "request while idle", 1, 0);
            if (rdy) begin
                k = -1;
                for (int b = 0; b < 7; b++) if (cmd_o[b]) k = b;
                take(k, int'(cmd_mr_idx_o), cmd_mr_data_o);
                if (k == 6 && cmd_mr_idx_o != 2'd3) dev[cmd_mr_idx_o] = cmd_mr_data_o;
                gap = 0;
            end
            if (ar) begin take(9, int'(mrrd_idx_o), '0); gap = 0; end
            if (ac) begin take(7, -1, '0); gap = 0; end
            if (at) begin take(8, -1, '0); gap = 0; end
            if (done_o) begin
                done_cnt++;
                chk(!busy_o, "R10", "busy with done", busy_o, 0);
                chk(gap >= done_min, "R8", "cycles before done", gap, done_min);
                chk(gap <= done_min + SLACK, "R8", "done too late", gap, done_min + SLACK);
            end
            if (err_o) err_cnt++;
            mrrd_data_i = (mrrd_idx_o == 2'd3) ? '0 : dev[mrrd_idx_o];
            cmd_ready_i = rdy;
            mrrd_ack_i  = ar;
            clk_ack_i   = ac;
            tim_ack_i   = at;
            busy_prev   = busy_o;
        end
    end

    task automatic run_case(input string name, input int kind,
                            input logic [MR_W-1:0] t0, t1, t2, d0, d1, d2,
                            input bit poke);
        int n;
        dev[0] = d0; dev[1] = d1; dev[2] = d2;
        build(kind, t0, t1, t2);
        done_cnt = 0; err_cnt = 0;
        @(negedge clk); #1;
        start_i = 1'b1; mem_kind_i = 2'(kind);
        tgt_mr0_i = t0; tgt_mr1_i = t1; tgt_mr2_i = t2;
        @(negedge clk); #1;
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R10", {name, " busy after start"}, busy_o, 1);
        if (poke) begin
            while (!clk_req_o) @(negedge clk);
            #1;
            start_i = 1'b1; mem_kind_i = 2'd3; tgt_mr0_i = 16'hFFFF;
            @(negedge clk); #1;
            start_i = 1'b0;
        end
        n = 0;
        while (done_cnt == 0 && n < 30000) begin @(negedge clk); n++; end
        chk(n < 30000, "R10", {name, " run finished"}, n, 30000);
        repeat (4) @(negedge clk);
        chk(done_cnt == 1, "R10", {name, " done pulses"}, done_cnt, 1);
        chk(err_cnt == 0, "R10", {name, " error pulses"}, err_cnt, 0);
        chk(eq_kind.size() == 0, "R6", {name, " events left"}, eq_kind.size(), 0);
        chk(!busy_o, "R10", {name, " idle after done"}, busy_o, 0);
        eq_kind.delete(); eq_idx.delete(); eq_data.delete(); eq_min.delete(); eq_req.delete();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 190000);
        chk(0, "R10", "watchdog expired", cyc, 0);
        finish_run();
    end

    initial begin
        dev[0] = '0; dev[1] = '0; dev[2] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy_o && !done_o && !err_o, "R1", "status after reset", {busy_o, done_o, err_o}, 0);
        chk(!(cmd_valid_o || mrrd_req_o || clk_req_o || tim_req_o), "R1", "requests in reset", 1, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && !err_o, "R1", "status after release", {busy_o, done_o, err_o}, 0);

        // R4 DDR2 DLL-off entry, no DLL reset; mr2 differs but is not read
        run_case("ddr2_dll_off", 0, 16'h0532, 16'h0001, 16'h0009, 16'h0432, 16'h0000, 16'h0005, 1'b0);
        // R6 R7 DDR3 every register differs, DLL kept on
        run_case("ddr3_all", 1, 16'h1420, 16'h0006, 16'h0010, 16'h1210, 16'h0004, 16'h0008, 1'b0);
        // R7 GDDR3 unchanged registers, bit 0 set but DLL still on, final precharge
        run_case("gddr3_same", 2, 16'h0051, 16'h0001, 16'h0000, 16'h0051, 16'h0001, 16'h0000, 1'b0);
        // R4 GDDR3 DLL-off entry via bit 6
        run_case("gddr3_dll_off", 2, 16'h0051, 16'h0040, 16'h0003, 16'h0050, 16'h0000, 16'h0003, 1'b0);
        // R3 DDR3 register 2 matches, only 0 changes
        run_case("ddr3_mr2_same", 1, 16'h0022, 16'h0004, 16'h0018, 16'h0020, 16'h0004, 16'h0018, 1'b0);

        // R2 unsupported type
        err_cnt = 0;
        @(negedge clk); #1;
        start_i = 1'b1; mem_kind_i = 2'd3;
        @(negedge clk); #1;
        start_i = 1'b0;
        chk(err_o == 1'b1, "R2", "error pulse", err_o, 1);
        chk(busy_o == 1'b0, "R2", "busy on error", busy_o, 0);
        @(negedge clk); #1;
        chk(err_o == 1'b0, "R2", "error pulse width", err_o, 0);
        repeat (20) @(negedge clk);
        chk(err_cnt == 1, "R2", "error count", err_cnt, 1);
        chk(!busy_o, "R2", "still idle", busy_o, 0);

        // R10 start while busy is ignored
        run_case("ddr3_poke", 1, 16'h1420, 16'h0006, 16'h0010, 16'h1210, 16'h0004, 16'h0008, 1'b1);

        finish_run();
    end
endmodule